// File: doc/BRIEF.md
# Pushbutton Input Port with Release Capture

This block is a small memory-mapped input port for a set of four pushbuttons. Software reads the live level of each button and a sticky record of completed presses, and chooses which buttons may raise an interrupt. Every register uses the same one-hot layout: button 0 is bit 0 (0x1), and so on up to button 3 at bit 3 (0x8).

The raw button pins are active-low. Each pin passes through a two-flop synchroniser. An event bit latches when a synchronised button goes from held to released. Software clears event bits by writing ones to the event register. A common pattern is to write back the value just read, or to write 0xF. The interrupt line is a combinational function of the event and mask registers.

The register bus is a plain strobe interface. It has a byte address, a read strobe, a write strobe and 32-bit data. The read data is combinational and is zero whenever the read strobe is low.

Top module: `pb_port`

## Requirements
- R1: After reset, the level, mask and event registers all read as 0 and `irq` is low.
- R2: A read at byte offset 0x0 returns a 1 in bit n for each button n whose `keys_n` pin is low, and 0 in bits 31:4. The value reflects a pin change two rising clock edges after the change.
- R3: A write at offset 0x8 loads bits 3:0 of the write data into the mask register; a 1 enables that button's interrupt. A read at 0x8 returns the mask with bits 31:4 zero.
- R4: Event bit n (offset 0xC) is set at the third rising edge after `keys_n[n]` goes from low to high: not at the second edge, and never because of a press.
- R5: An event bit, once set, stays set through later presses and releases until software clears it.
- R6: A write at offset 0xC clears each event bit whose write-data bit is 1. Bits written as 0 keep their value.
- R7: If a release sets an event bit in the same cycle that a clearing write targets that bit, the bit ends up set.
- R8: `irq` is high exactly when some bit is set in both the event and mask registers. It follows register changes in the same cycle.
- R9: A read at an unused offset (0x4) returns 0. Writes to offsets 0x0 and 0x4 change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| keys_n | input | 4 | Raw button pins, low while pressed |
| addr | input | 4 | Register byte offset |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational, zero when `rd_en` is low |
| irq | output | 1 | Interrupt request |

## Verification
Results fall due at three distinct times:
- A level read reflects a pin change after the second rising edge.
- An event bit appears after the third rising edge following a release.
- Register writes, and `irq`, take effect at the edge that ends the write cycle.

The bench moves stimulus one time unit after a rising edge and counts those edges exactly before it queues an expected value. The monitor compares each result at the falling edge of the cycle in which it is due. The release-capture check reads the event register both one cycle early and exactly on time, which pins the latency rather than merely bounding it. The collision case places the clearing write in the same cycle as the release that the synchroniser delivers.

// File: rtl/pb_port.sv
module pb_port #(
  parameter int NUM_KEYS = 4,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_KEYS-1:0] keys_n,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                rd_en,
  input  logic                wr_en,
  input  logic [DATA_W-1:0]   wdata,
  output logic [DATA_W-1:0]   rdata,
  output logic                irq
);

  localparam logic [ADDR_W-1:0] OFS_LEVEL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFS_MASK  = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] OFS_EVENT = ADDR_W'(12);
  localparam int               PAD_W     = DATA_W - NUM_KEYS;

  logic [NUM_KEYS-1:0] sync1_n, sync2_n, held_d;
  logic [NUM_KEYS-1:0] held, rel, clr;
  logic [NUM_KEYS-1:0] mask_q, cap_q;
  logic                unused_hi;

  assign unused_hi = ^wdata[DATA_W-1:NUM_KEYS];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync1_n <= '1;
      sync2_n <= '1;
      held_d  <= '0;
    end else begin
      sync1_n <= keys_n;
      sync2_n <= sync1_n;
      held_d  <= held;
    end

  assign held = ~sync2_n;
  assign rel  = held_d & ~held;
  assign clr  = (wr_en && addr == OFS_EVENT) ? wdata[NUM_KEYS-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mask_q <= '0;
      cap_q  <= '0;
    end else begin
      cap_q <= (cap_q & ~clr) | rel;
      if (wr_en && addr == OFS_MASK) mask_q <= wdata[NUM_KEYS-1:0];
    end

  always_comb begin
    rdata = '0;
    if (rd_en)
      case (addr)
        OFS_LEVEL: rdata = {{PAD_W{1'b0}}, held};
        OFS_MASK:  rdata = {{PAD_W{1'b0}}, mask_q};
        OFS_EVENT: rdata = {{PAD_W{1'b0}}, cap_q};
        default:   rdata = '0;
      endcase
  end

  assign irq = |(cap_q & mask_q);

endmodule

// File: rtl/pb_port_chk.sv
module pb_port_chk #(
  parameter int NUM_KEYS = 4,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic [ADDR_W-1:0]   addr,
  input logic                rd_en,
  input logic                wr_en,
  input logic [DATA_W-1:0]   rdata,
  input logic                irq,
  input logic [NUM_KEYS-1:0] cap_q,
  input logic [NUM_KEYS-1:0] mask_q,
  input logic [NUM_KEYS-1:0] rel
);

  logic ev_wr, mk_wr;
  assign ev_wr = wr_en && addr == ADDR_W'(12);
  assign mk_wr = wr_en && addr == ADDR_W'(8);

  // R3: mask only moves on a mask write
  assert_mask_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !mk_wr |=> $stable(mask_q));

  // R4: a new event bit needs a release in the previous cycle
  assert_set_by_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((cap_q & ~$past(cap_q) & ~$past(rel)) == '0));

  // R5: without a clearing write no event bit drops
  assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_wr |=> ((cap_q & $past(cap_q)) == $past(cap_q)));

  // R7: release wins over a same-cycle clear
  assert_release_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_wr && rel != '0) |=> ((cap_q & $past(rel)) == $past(rel)));

  // R8: interrupt needs both an event and an enable
  assert_irq_needs_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (cap_q != '0 && mask_q != '0));

  // R9: unused offset reads zero
  assert_unused_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == ADDR_W'(4)) |-> rdata == '0);

  // R1: nothing pending right out of reset
  assert_reset_quiet_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> !irq);

endmodule

bind pb_port pb_port_chk #(.NUM_KEYS(NUM_KEYS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
  .rdata(rdata), .irq(irq), .cap_q(cap_q), .mask_q(mask_q), .rel(rel)
);

// File: tb/pb_port_bench.sv
`timescale 1ns/1ps
module pb_port_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  keys_n = 4'hF;
  logic [3:0]  addr = '0;
  logic        rd_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  logic        probe = 1'b0;

  typedef struct {
    bit          is_irq;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t queue_q[$];
  int    n_vec = 0;
  int    n_bad = 0;
  bit    done  = 1'b0;

  always #2.5 clk = ~clk;

  pb_port u_pb_port (
    .clk(clk), .rst_n(rst_n), .keys_n(keys_n), .addr(addr), .rd_en(rd_en),
    .wr_en(wr_en), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  task automatic tick(input int n);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] e, input string tag);
    item_t it;
    it.is_irq = 1'b0; it.exp = e; it.tag = tag;
    queue_q.push_back(it);
    addr = a; rd_en = 1'b1;
    tick(1);
    rd_en = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    tick(1);
    wr_en = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string tag);
    item_t it;
    it.is_irq = 1'b1; it.exp = {31'b0, e}; it.tag = tag;
    queue_q.push_back(it);
    probe = 1'b1;
    tick(1);
    probe = 1'b0;
  endtask

  // monitor: compare in the middle of each cycle a result is due
  always @(negedge clk) begin
    if (rd_en || probe) begin
      item_t it;
      logic [31:0] got;
      it = queue_q.pop_front();
      got = it.is_irq ? {31'b0, irq} : rdata;
      n_vec++;
      if (got !== it.exp) begin
        n_bad++;
        $display("FAIL %s: got %h expected %h", it.tag, got, it.exp);
      end
    end
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R1
    rd(4'h0, 32'h0, "R1 level");
    rd(4'h8, 32'h0, "R1 mask");
    rd(4'hC, 32'h0, "R1 event");
    chk_irq(1'b0, "R1 irq");

    // R2: press button 0, then button 3
    keys_n = 4'b1110;
    tick(2);
    rd(4'h0, 32'h1, "R2 level b0");
    rd(4'hC, 32'h0, "R4 press sets nothing");
    keys_n = 4'b0110;
    tick(2);
    rd(4'h0, 32'h9, "R2 level b0 b3");

    // R4: release button 0, event at third edge
    keys_n = 4'b0111;
    tick(2);
    rd(4'hC, 32'h0, "R4 not yet at edge 2");
    rd(4'hC, 32'h1, "R4 set at edge 3");
    keys_n = 4'b1111;
    tick(3);
    rd(4'hC, 32'h9, "R4 b3 release");

    // R5: press and release button 0 again
    keys_n = 4'b1110;
    tick(3);
    rd(4'hC, 32'h9, "R5 sticky while held");
    keys_n = 4'b1111;
    tick(3);
    rd(4'hC, 32'h9, "R5 sticky after release");

    // R8 / R3
    chk_irq(1'b0, "R8 mask zero");
    wr(4'h8, 32'h2);
    chk_irq(1'b0, "R8 mask no overlap");
    rd(4'h8, 32'h2, "R3 mask readback");
    wr(4'h8, 32'hFFFF_FFF8);
    rd(4'h8, 32'h8, "R3 mask upper bits dropped");
    chk_irq(1'b1, "R8 overlap on b3");

    // R6
    wr(4'hC, 32'h8);
    rd(4'hC, 32'h1, "R6 clear b3 only");
    chk_irq(1'b0, "R8 irq drops with clear");
    wr(4'hC, 32'h0);
    rd(4'hC, 32'h1, "R6 zero write keeps");
    wr(4'hC, 32'h1);
    rd(4'hC, 32'h0, "R6 write back clears");

    // R9
    rd(4'h4, 32'h0, "R9 unused read");
    wr(4'h0, 32'hF);
    wr(4'h4, 32'hF);
    rd(4'h8, 32'h8, "R9 mask untouched");
    rd(4'hC, 32'h0, "R9 event untouched");

    // R7: collision of release and clear on b1
    keys_n = 4'b1001;
    tick(2);
    keys_n = 4'b1111;
    tick(3);
    rd(4'hC, 32'h6, "R7 setup b1 b2");
    keys_n = 4'b1101;
    tick(3);
    keys_n = 4'b1111;
    tick(2);
    wr(4'hC, 32'h6);
    rd(4'hC, 32'h2, "R7 release wins");
    wr(4'h8, 32'h2);
    chk_irq(1'b1, "R8 irq on b1");

    // all buttons
    keys_n = 4'b0000;
    tick(2);
    rd(4'h0, 32'hF, "R2 all held");
    keys_n = 4'b1111;
    tick(3);
    rd(4'hC, 32'hF, "R4 all released");
    wr(4'hC, 32'hF);
    rd(4'hC, 32'h0, "R6 clear all");
    chk_irq(1'b0, "R8 idle");

    tick(2);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule